// File: doc/BRIEF.md
# DMA Channel Address and Count Registers

This block keeps the address and count state of one channel of a simple DMA controller. It holds a source pointer and a destination pointer, each 20 bits wide. Each pointer has a software-written value and a working copy that advances during a transfer. The block also holds a 16-bit reload register and a live transfer counter. Software reaches all of this, and a small control byte, through a byte-wide register bus. Writes take effect on the clock edge. Reads are combinational from the address.

The controller core issues a one-cycle `step_i` strobe for each completed transfer. While the channel is enabled, each step advances every forward-direction working pointer by one and counts the live counter down. A step taken with the counter at zero is an underflow. In single-shot mode an underflow disables the channel and raises a done pulse. In repeat mode it reloads the counter and the forward working pointers, and the channel stays enabled.

The block carries no streaming data, so it has no valid/ready interface. The register bus and the step strobe are plain one-cycle strobes with no back-pressure. Each strobe is acted on in the cycle it is high.

The register map is as follows:
- Offsets 0 to 2 hold the source pointer, least significant byte first.
- Offsets 3 to 5 hold the destination pointer, in the same byte order.
- Offsets 6 and 7 hold the count, low byte then high byte.
- Offset 8 is the control byte. Bit 0 enables the channel. Bit 1 makes the source forward-counting, with 0 meaning fixed. Bit 2 does the same for the destination. Bit 3 selects repeat mode.
- All other offsets read 0.

After reset the control byte is 0 and both pulses are low. The pointers, the reload register and the counter hold unspecified values until software writes them. If an underflow in single-shot mode falls in the same cycle as a software write of the enable bit, the underflow's clear of the enable bit wins.

Top module: `dma_chan_regs`

## Requirements
- R1: Pointers store 20 bits. The upper nibble of byte offsets 2 and 5 always reads 0, whatever is written to it.
- R2: A write to a fixed-direction pointer is ignored while the channel is enabled. The same write is stored while the channel is disabled.
- R3: A write to a forward-direction pointer is stored at any time, including while the channel is enabled.
- R4: A pointer read returns the working pointer when that pointer is forward and the channel is enabled. Otherwise it returns the last written value.
- R5: A write to offsets 6 or 7 goes to the reload register only. Reads of 6 and 7 return the live counter, which that write leaves unchanged.
- R6: Writing 1 to control bit 0 while it is 0 copies the reload value into the live counter and each written pointer value into its working pointer.
- R7: A step while enabled does three things: it adds one to each forward working pointer, wrapping modulo 2^20; it leaves fixed pointers unchanged; and it counts the live counter down by one. A step while disabled changes nothing.
- R8: In single-shot mode (control bit 3 = 0), a step at count 0000h is an underflow, with these effects:
  - control bit 0 clears;
  - `done_o` and `underflow_o` go high for exactly the next cycle;
  - the counter reads FFFFh afterwards.
- R9: In repeat mode, an underflow reloads the live counter from the reload register and each forward working pointer from its written value. It pulses `underflow_o` but not `done_o`, and the channel stays enabled.
- R10: After reset, the control byte reads 0, `chan_en_o`, `underflow_o` and `done_o` are low, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_addr | input | 4 | Register byte offset for read and write |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr` (combinational) |
| step_i | input | 1 | One-cycle transfer-completed strobe from the core |
| chan_en_o | output | 1 | Channel enable state (control bit 0) |
| underflow_o | output | 1 | One-cycle pulse after a counter underflow |
| done_o | output | 1 | One-cycle pulse after a single-shot underflow |

## Verification
The bench checks the points where a wrong design would show a wrong value at the ports:
- **Read-back view.** A forward pointer written while enabled must read back the working value, then the new written value once disabled. A design with the view select inverted shows the wrong one in one of those two states.
- **Fixed-pointer lock.** A write to a fixed pointer while enabled must be dropped. A design that ignores the lock reads the rejected byte.
- **Count read.** Reading the count must return the live counter. A design that returns the reload register shows the newly written value instead.
- **Underflow.** The bench checks the 20-bit pointer wrap, the FFFFh counter after a single-shot underflow, and the difference between the two modes. A design that keeps the channel enabled, or that skips the reload, shows the wrong flags, count or pointer.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int PTR_W_DEF = 20;
  localparam int CNT_W_DEF = 16;
  localparam int REG_AW_DEF = 4;

  typedef struct packed {
    logic rpt;
    logic dst_fwd;
    logic src_fwd;
    logic en;
  } chan_ctrl_t;
endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
  parameter int PTR_W = 20,
  parameter int BYTES = (PTR_W + 7) / 8,
  parameter int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [7:0]           wr_data,
  input  logic                 fwd,
  input  logic                 chan_en,
  input  logic                 load,
  input  logic                 step,
  output logic [BYTES*8-1:0]   view_o,
  output logic [PTR_W-1:0]     shadow_o
);
  logic [PTR_W-1:0]   shadow_q;
  logic [PTR_W-1:0]   work_q;
  logic [PTR_W-1:0]   shadow_nx;
  logic [BYTES*8-1:0] pad;

  always_comb begin
    pad = '0;
    pad[PTR_W-1:0] = shadow_q;
    pad[int'(wr_sel)*8 +: 8] = wr_data;
    shadow_nx = pad[PTR_W-1:0];
  end

  // Data state carries no reset: contents are undefined until programmed.
  always_ff @(posedge clk) begin
    if (wr_en && (fwd || !chan_en))
      shadow_q <= shadow_nx;
    if (load)
      work_q <= shadow_q;
    else if (step && fwd)
      work_q <= work_q + PTR_W'(1);
  end

  always_comb begin
    view_o = '0;
    view_o[PTR_W-1:0] = (fwd && chan_en) ? work_q : shadow_q;
  end

  assign shadow_o = shadow_q;
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int CNT_W = 16,
  parameter int BYTES = (CNT_W + 7) / 8,
  parameter int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [7:0]         wr_data,
  input  logic               start,
  input  logic               step,
  input  logic               rpt,
  output logic               zero_o,
  output logic [CNT_W-1:0]   live_o
);
  logic [CNT_W-1:0]   reload_q;
  logic [CNT_W-1:0]   live_q;
  logic [CNT_W-1:0]   reload_nx;
  logic [BYTES*8-1:0] pad;

  always_comb begin
    pad = '0;
    pad[CNT_W-1:0] = reload_q;
    pad[int'(wr_sel)*8 +: 8] = wr_data;
    reload_nx = pad[CNT_W-1:0];
  end

  assign zero_o = (live_q == '0);

  always_ff @(posedge clk) begin
    if (wr_en)
      reload_q <= reload_nx;
    if (start)
      live_q <= reload_q;
    else if (step) begin
      if (zero_o && rpt)
        live_q <= reload_q;
      else
        live_q <= live_q - CNT_W'(1);
    end
  end

  assign live_o = live_q;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int PTR_W  = PTR_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  parameter int REG_AW = REG_AW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              step_i,
  output logic              chan_en_o,
  output logic              underflow_o,
  output logic              done_o
);
  localparam int PTR_BYTES = (PTR_W + 7) / 8;
  localparam int CNT_BYTES = (CNT_W + 7) / 8;
  localparam int PSEL_W    = (PTR_BYTES > 1) ? $clog2(PTR_BYTES) : 1;
  localparam int CSEL_W    = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1;
  localparam int NUM_PTR   = 2;
  localparam int CNT_BASE  = NUM_PTR * PTR_BYTES;
  localparam int CTRL_ADDR = CNT_BASE + CNT_BYTES;

  chan_ctrl_t ctrl_q;
  logic       uf_q, done_q;
  int         addr_i;
  logic       ctrl_hit, cnt_hit;
  logic       en_rise, step_act, cnt_zero, uf_now, ptr_load;
  logic [CNT_W-1:0]         live_cnt;
  logic [PTR_BYTES*8-1:0]   ptr_view   [NUM_PTR];
  logic [PTR_W-1:0]         ptr_shadow [NUM_PTR];

  assign addr_i   = int'(reg_addr);
  assign ctrl_hit = (addr_i == CTRL_ADDR);
  assign cnt_hit  = (addr_i >= CNT_BASE) && (addr_i < CNT_BASE + CNT_BYTES);
  assign en_rise  = reg_wr && ctrl_hit && reg_wdata[0] && !ctrl_q.en;
  assign step_act = step_i && ctrl_q.en;
  assign uf_now   = step_act && cnt_zero;
  assign ptr_load = en_rise || (uf_now && ctrl_q.rpt);

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    localparam int BASE = g * PTR_BYTES;
    logic hit;
    logic fwd;
    assign hit = (addr_i >= BASE) && (addr_i < BASE + PTR_BYTES);
    assign fwd = (g == 0) ? ctrl_q.src_fwd : ctrl_q.dst_fwd;
    dma_ptr_unit #(.PTR_W(PTR_W), .BYTES(PTR_BYTES), .SEL_W(PSEL_W)) u_ptr (
      .clk      (clk),
      .wr_en    (reg_wr && hit),
      .wr_sel   (PSEL_W'(addr_i - BASE)),
      .wr_data  (reg_wdata),
      .fwd      (fwd),
      .chan_en  (ctrl_q.en),
      .load     (ptr_load),
      .step     (step_act),
      .view_o   (ptr_view[g]),
      .shadow_o (ptr_shadow[g])
    );
  end

  dma_count_unit #(.CNT_W(CNT_W), .BYTES(CNT_BYTES), .SEL_W(CSEL_W)) u_cnt (
    .clk     (clk),
    .wr_en   (reg_wr && cnt_hit),
    .wr_sel  (CSEL_W'(addr_i - CNT_BASE)),
    .wr_data (reg_wdata),
    .start   (en_rise),
    .step    (step_act),
    .rpt     (ctrl_q.rpt),
    .zero_o  (cnt_zero),
    .live_o  (live_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      uf_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      uf_q   <= uf_now;
      done_q <= uf_now && !ctrl_q.rpt;
      if (reg_wr && ctrl_hit)
        ctrl_q <= chan_ctrl_t'(reg_wdata[3:0]);
      if (uf_now && !ctrl_q.rpt)
        ctrl_q.en <= 1'b0;
    end
  end

  always_comb begin
    logic [CNT_BYTES*8-1:0] cnt_pad;
    cnt_pad = '0;
    cnt_pad[CNT_W-1:0] = live_cnt;
    reg_rdata = '0;
    if (addr_i < PTR_BYTES)
      reg_rdata = ptr_view[0][addr_i*8 +: 8];
    else if (addr_i < CNT_BASE)
      reg_rdata = ptr_view[1][(addr_i - PTR_BYTES)*8 +: 8];
    else if (cnt_hit)
      reg_rdata = cnt_pad[(addr_i - CNT_BASE)*8 +: 8];
    else if (ctrl_hit)
      reg_rdata = {4'b0, ctrl_q};
  end

  assign chan_en_o   = ctrl_q.en;
  assign underflow_o = uf_q;
  assign done_o      = done_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int PTR_W  = 20,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              step_i,
  input logic              chan_en_o,
  input logic              underflow_o,
  input logic              done_o,
  input logic [3:0]        ctrl_bits,
  input logic [CNT_W-1:0]  live_cnt,
  input logic [PTR_W-1:0]  src_shadow,
  input logic [PTR_W-1:0]  dst_shadow
);
  localparam int PTR_BYTES = (PTR_W + 7) / 8;
  localparam int CNT_BYTES = (CNT_W + 7) / 8;
  localparam int SRC_TOP   = PTR_BYTES - 1;
  localparam int DST_TOP   = 2 * PTR_BYTES - 1;
  localparam int TOP_BITS  = PTR_W - (PTR_BYTES - 1) * 8;
  localparam int CTRL_ADDR = 2 * PTR_BYTES + CNT_BYTES;

  logic ctrl_wr, en_wr;
  assign ctrl_wr = reg_wr && (int'(reg_addr) == CTRL_ADDR);
  assign en_wr   = ctrl_wr && reg_wdata[0];

  AST_PTR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) == SRC_TOP || int'(reg_addr) == DST_TOP) |-> ((reg_rdata >> TOP_BITS) == 8'h00)); // R1
  AST_FIXED_SRC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en_o && !ctrl_bits[1]) |=> $stable(src_shadow)); // R2
  AST_FIXED_DST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en_o && !ctrl_bits[2]) |=> $stable(dst_shadow)); // R2
  AST_STEP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en_o && step_i && live_cnt != '0) |=> (live_cnt == CNT_W'($past(live_cnt) - CNT_W'(1)))); // R7
  AST_IDLE_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en_o && !en_wr) |=> $stable(live_cnt)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!chan_en_o && underflow_o)); // R8
  AST_REPEAT_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_o && !done_o) |-> (chan_en_o || $past(ctrl_wr))); // R9
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W), .REG_AW(REG_AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .step_i      (step_i),
  .chan_en_o   (chan_en_o),
  .underflow_o (underflow_o),
  .done_o      (done_o),
  .ctrl_bits   (ctrl_q),
  .live_cnt    (live_cnt),
  .src_shadow  (ptr_shadow[0]),
  .dst_shadow  (ptr_shadow[1])
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       step_i;
  logic       chan_en_o, underflow_o, done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step_i(step_i),
    .chan_en_o(chan_en_o), .underflow_o(underflow_o), .done_o(done_o)
  );

  // Operation codes: read-compare, write, step, flag-compare {done,underflow,enable}
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_ST = 2'd2, OP_FL = 2'd3;
  localparam int NV = 49;
  // {op, addr, data, expected, requirement number}
  localparam logic [25:0] VEC [NV] = '{
    {OP_WR, 4'd0, 8'h34, 8'h00, 4'd1},
    {OP_WR, 4'd1, 8'h12, 8'h00, 4'd1},
    {OP_WR, 4'd2, 8'hFA, 8'h00, 4'd1},   // R1 upper nibble dropped
    {OP_RD, 4'd2, 8'h00, 8'h0A, 4'd1},   // R1
    {OP_WR, 4'd3, 8'h00, 8'h00, 4'd2},
    {OP_WR, 4'd4, 8'h50, 8'h00, 4'd2},
    {OP_WR, 4'd5, 8'h03, 8'h00, 4'd2},
    {OP_WR, 4'd6, 8'h01, 8'h00, 4'd5},
    {OP_WR, 4'd7, 8'h00, 8'h00, 4'd5},
    {OP_WR, 4'd8, 8'h03, 8'h00, 4'd6},   // enable, src forward, dst fixed, single-shot
    {OP_RD, 4'd0, 8'h00, 8'h34, 4'd6},   // R6 working pointer copied
    {OP_RD, 4'd6, 8'h00, 8'h01, 4'd6},   // R6 live counter loaded
    {OP_WR, 4'd3, 8'h77, 8'h00, 4'd2},   // R2 fixed write while enabled
    {OP_RD, 4'd3, 8'h00, 8'h00, 4'd2},   // R2 ignored
    {OP_ST, 4'd0, 8'h00, 8'h00, 4'd7},
    {OP_FL, 4'd0, 8'h00, 8'h01, 4'd7},
    {OP_RD, 4'd0, 8'h00, 8'h35, 4'd7},   // R7 forward increment
    {OP_RD, 4'd6, 8'h00, 8'h00, 4'd7},   // R7 count down
    {OP_RD, 4'd4, 8'h00, 8'h50, 4'd7},   // R7 fixed pointer unchanged
    {OP_WR, 4'd0, 8'h99, 8'h00, 4'd3},   // R3 forward write while enabled
    {OP_RD, 4'd0, 8'h00, 8'h35, 4'd4},   // R4 still shows working pointer
    {OP_ST, 4'd0, 8'h00, 8'h00, 4'd8},   // underflow, single-shot
    {OP_FL, 4'd0, 8'h00, 8'h06, 4'd8},   // R8 done + underflow, enable clear
    {OP_FL, 4'd0, 8'h00, 8'h00, 4'd8},   // R8 pulses last one cycle
    {OP_RD, 4'd0, 8'h00, 8'h99, 4'd3},   // R3 write kept, R4 written view
    {OP_RD, 4'd6, 8'h00, 8'hFF, 4'd8},
    {OP_RD, 4'd7, 8'h00, 8'hFF, 4'd8},   // R8 counter FFFFh
    {OP_RD, 4'd8, 8'h00, 8'h02, 4'd8},
    {OP_ST, 4'd0, 8'h00, 8'h00, 4'd7},   // R7 step while disabled
    {OP_RD, 4'd6, 8'h00, 8'hFF, 4'd7},
    {OP_WR, 4'd6, 8'h05, 8'h00, 4'd5},   // R5 reload write
    {OP_RD, 4'd6, 8'h00, 8'hFF, 4'd5},   // R5 live unchanged
    {OP_WR, 4'd6, 8'h01, 8'h00, 4'd5},
    {OP_WR, 4'd3, 8'hFF, 8'h00, 4'd2},   // R2 accepted while disabled
    {OP_WR, 4'd4, 8'hFF, 8'h00, 4'd2},
    {OP_WR, 4'd5, 8'hFF, 8'h00, 4'd1},
    {OP_RD, 4'd3, 8'h00, 8'hFF, 4'd2},
    {OP_WR, 4'd8, 8'h0F, 8'h00, 4'd6},   // enable, both forward, repeat
    {OP_RD, 4'd6, 8'h00, 8'h01, 4'd6},
    {OP_ST, 4'd0, 8'h00, 8'h00, 4'd7},
    {OP_RD, 4'd0, 8'h00, 8'h9A, 4'd7},
    {OP_RD, 4'd5, 8'h00, 8'h00, 4'd7},   // R7 wrap to 00000h
    {OP_ST, 4'd0, 8'h00, 8'h00, 4'd9},   // underflow, repeat
    {OP_FL, 4'd0, 8'h00, 8'h03, 4'd9},   // R9 underflow, no done, still enabled
    {OP_RD, 4'd6, 8'h00, 8'h01, 4'd9},   // R9 counter reloaded
    {OP_RD, 4'd0, 8'h00, 8'h99, 4'd9},   // R9 source reloaded
    {OP_RD, 4'd5, 8'h00, 8'h0F, 4'd9},   // R9 destination reloaded
    {OP_WR, 4'd8, 8'h00, 8'h00, 4'd10},
    {OP_RD, 4'd9, 8'h00, 8'h00, 4'd10}   // R10 unmapped offset
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] flags();
    return {5'b0, done_o, underflow_o, chan_en_o};
  endfunction

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; step_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    reg_addr = 4'd8; #1;
    check(reg_rdata, 8'h00, "R10 control after reset");
    check(flags(), 8'h00, "R10 flags after reset");
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][25:24];
      @(negedge clk);
      reg_addr  = VEC[i][23:20];
      reg_wdata = VEC[i][19:12];
      reg_wr    = (op == OP_WR);
      step_i    = (op == OP_ST);
      #1;
      if (op == OP_RD)
        check(reg_rdata, VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
      else if (op == OP_FL)
        check(flags(), VEC[i][11:4], $sformatf("R%0d vector %0d flags", VEC[i][3:0], i));
    end
    @(negedge clk);
    reg_wr = 1'b0; step_i = 1'b0;
    // R1 upper nibble of destination top byte
    reg_addr = 4'd5; #1;
    check(reg_rdata, 8'h0F, "R1 destination top byte");
    // R10 reset while enabled and mid-pulse
    reg_addr = 4'd8; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; #1;
    check(reg_rdata, 8'h00, "R10 control after second reset");
    check(flags(), 8'h00, "R10 flags after second reset");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule